// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is a synthesizable behavioural model of the command side of a parallel NOR flash with 16-bit words. It watches active-low chip-enable, write-enable and output-enable strobes, plus a write-protect input. Write cycles are assembled into multi-step unlock and command sequences. The decoded commands are word program, sector erase, block erase, erase suspend and erase resume. The array is a small register array, erased to FFFFh at reset. The internal busy times are counted in clock cycles.

While an internal program or erase runs, reads return polling status instead of array data. Every write is then ignored, except the suspend byte during an erase. A suspended erase can be resumed. While it is suspended, words outside the suspended unit can still be read and programmed. The geometry is scaled down by parameters. By default there are 256 words, a sector is 16 words, a block is 64 words, and block 0 is the protectable block.

Top module: `fcsm_top`

## Requirements
- R1: A write cycle spans the cycles where ce_n and we_n are both low. Its address is sampled in the first such cycle and its data in the last such cycle, so later address changes and earlier data values have no effect.
- R2: The sequence 00AAh@5555h, 0055h@2AAAh, 00A0h@5555h, then data@address programs that word. Only the low data byte is compared in command cycles, and the array index is the low 8 address bits. The new value reads back once the program busy time (PROG_CYC cycles) has elapsed.
- R3: A program to a word that does not read FFFFh is dropped: the word keeps its old value and no busy status appears.
- R4: The six-cycle sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h@address erases the 16-word sector holding that address to FFFFh. No other word changes.
- R5: The same sequence ending in 50h erases the 64-word block holding the address.
- R6: During a program or erase, a read returns status. Bit 7 is the complement of the programmed bit 7, or 0 during an erase. Bit 6 toggles between consecutive reads. All other bits are 0. Any full command sequence issued during this time has no effect.
- R7: A single write of B0h during an erase suspends it. After SUSP_CYC cycles, a read inside the suspended unit returns bit 6 = 1, bit 2 toggling on each read and all other bits 0. Reads elsewhere return array data.
- R8: While an erase is suspended, a program outside the suspended unit works as in R2, after which the erase stays suspended. A program inside the suspended unit is dropped.
- R9: A single write of 30h while suspended resumes the erase, which then completes and clears its unit.
- R10: With wp_n low, a sector or block erase aimed at block 0 is dropped. With wp_n high, the same erase is carried out.
- R11: A command cycle carrying a wrong byte or address returns the sequencer to idle. A following partial sequence then programs nothing.
- R12: dq_oe is 1 only while ce_n and oe_n are both low. Otherwise dq_out is 0000h.
- R13: After reset every word reads FFFFh and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wp_n | input | 1 | Write protect for block 0, active low |
| addr | input | 16 | Word address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data or status |
| dq_oe | output | 1 | High when dq_out is being driven |

## Verification
A wrong sequencer state shows up at the next completed write: a word that should change stays FFFFh, or a word changes that should not. This becomes visible one busy period later on read-back. A wrong engine mode shows up on the very next read. Status appears where array data was expected, or the reverse, or bit 2 and bit 6 stop alternating between two back-to-back reads. A lost or corrupted erase counter only shows after the full erase time, as words that are not cleared or as a suspend that never ends.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;
    localparam int WORD_W = 16;
    localparam int BUS_AW = 16;

    localparam logic [BUS_AW-1:0] UNLK_ADDR_A = 16'h5555;
    localparam logic [BUS_AW-1:0] UNLK_ADDR_B = 16'h2AAA;
    localparam logic [7:0] BYTE_KEY_A  = 8'hAA;
    localparam logic [7:0] BYTE_KEY_B  = 8'h55;
    localparam logic [7:0] BYTE_PROG   = 8'hA0;
    localparam logic [7:0] BYTE_ERASE  = 8'h80;
    localparam logic [7:0] BYTE_SECT   = 8'h30;
    localparam logic [7:0] BYTE_BLK    = 8'h50;
    localparam logic [7:0] BYTE_SUSP   = 8'hB0;
    localparam logic [7:0] BYTE_RESUME = 8'h30;

    typedef enum logic [2:0] {
        MD_READY, MD_PROG, MD_ERASE, MD_SUSPING, MD_SUSP
    } mode_e;

    typedef enum logic [2:0] {
        CK_NONE, CK_PROG, CK_SECT, CK_BLK, CK_SUSP, CK_RESUME
    } cmd_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_K1, SQ_K2, SQ_PDATA, SQ_E3, SQ_E4, SQ_E5
    } seq_e;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_t;

    typedef struct packed {
        cmd_kind_e         kind;
        logic [BUS_AW-1:0] addr;
        logic [WORD_W-1:0] data;
    } cmd_t;

    function automatic logic is_busy(mode_e m);
        return (m == MD_PROG) || (m == MD_ERASE) || (m == MD_SUSPING);
    endfunction

    // True when a and b fall in the same 2**sh word unit of a 2**aw array.
    function automatic logic same_unit(logic [BUS_AW-1:0] a, logic [BUS_AW-1:0] b,
                                       int unsigned aw, int unsigned sh);
        logic [BUS_AW-1:0] m;
        m = BUS_AW'((32'd1 << aw) - 32'd1) & ~BUS_AW'((32'd1 << sh) - 32'd1);
        return ((a ^ b) & m) == '0;
    endfunction
endpackage

// File: rtl/fcsm_wr_capture.sv
module fcsm_wr_capture
    import fcsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic              wr_evt,
    output wr_t               wr
);
    logic              act, act_q;
    logic [BUS_AW-1:0] a_q;
    logic [WORD_W-1:0] d_q;

    assign act = !ce_n && !we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            a_q   <= '0;
            d_q   <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) a_q <= addr;   // later falling strobe
            if (act)           d_q <= din;    // value held at earlier rising strobe
        end
    end

    assign wr_evt  = act_q && !act;
    assign wr.addr = a_q;
    assign wr.data = d_q;
endmodule

// File: rtl/fcsm_cmd_decode.sv
module fcsm_cmd_decode
    import fcsm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_evt,
    input  wr_t   wr,
    input  logic  busy,
    output cmd_t  cmd
);
    seq_e       st;
    logic [7:0] lo;
    logic       at_a, at_b;

    assign lo   = wr.data[7:0];
    assign at_a = (wr.addr == UNLK_ADDR_A);
    assign at_b = (wr.addr == UNLK_ADDR_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_IDLE;
            cmd <= '{kind: CK_NONE, addr: '0, data: '0};
        end else begin
            cmd.kind <= CK_NONE;
            cmd.addr <= wr.addr;
            cmd.data <= wr.data;
            if (wr_evt) begin
                if (busy) begin
                    st <= SQ_IDLE;
                    if (lo == BYTE_SUSP) cmd.kind <= CK_SUSP;
                end else begin
                    unique case (st)
                        SQ_IDLE: begin
                            if (at_a && lo == BYTE_KEY_A) st <= SQ_K1;
                            else if (lo == BYTE_RESUME) cmd.kind <= CK_RESUME;
                        end
                        SQ_K1: st <= (at_b && lo == BYTE_KEY_B) ? SQ_K2 : SQ_IDLE;
                        SQ_K2: begin
                            if (at_a && lo == BYTE_PROG)       st <= SQ_PDATA;
                            else if (at_a && lo == BYTE_ERASE) st <= SQ_E3;
                            else                               st <= SQ_IDLE;
                        end
                        SQ_PDATA: begin
                            cmd.kind <= CK_PROG;
                            st       <= SQ_IDLE;
                        end
                        SQ_E3: st <= (at_a && lo == BYTE_KEY_A) ? SQ_E4 : SQ_IDLE;
                        SQ_E4: st <= (at_b && lo == BYTE_KEY_B) ? SQ_E5 : SQ_IDLE;
                        SQ_E5: begin
                            if (lo == BYTE_SECT)     cmd.kind <= CK_SECT;
                            else if (lo == BYTE_BLK) cmd.kind <= CK_BLK;
                            st <= SQ_IDLE;
                        end
                        default: st <= SQ_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/fcsm_core.sv
module fcsm_core
    import fcsm_pkg::*;
#(
    parameter int AW        = 8,
    parameter int SECT_AW   = 4,
    parameter int BLK_AW    = 6,
    parameter int PROT_BLK  = 0,
    parameter int PROG_CYC  = 40,
    parameter int ERASE_CYC = 80,
    parameter int SUSP_CYC  = 10,
    parameter int CNT_W     = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  cmd_t              cmd,
    input  logic [AW-1:0]     raddr,
    output mode_e             mode,
    output logic [WORD_W-1:0] rword,
    output logic [WORD_W-1:0] pdata,
    output logic [BUS_AW-1:0] ebase,
    output logic              eblk,
    output logic [CNT_W-1:0]  ecnt
);
    localparam int DEPTH = 1 << AW;
    localparam logic [BUS_AW-1:0] PROT_BASE = BUS_AW'(PROT_BLK) << BLK_AW;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  pcnt;
    logic [AW-1:0]     paddr;
    logic              parked;
    logic              tgt_blank, prot_hit, in_susp;
    int unsigned       eshift;

    assign eshift    = eblk ? BLK_AW : SECT_AW;
    assign tgt_blank = (mem[cmd.addr[AW-1:0]] == '1);
    assign prot_hit  = !wp_n && same_unit(cmd.addr, PROT_BASE, AW, BLK_AW);
    assign in_susp   = same_unit(cmd.addr, ebase, AW, eshift);
    assign rword     = mem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MD_READY;
            pcnt   <= '0;
            ecnt   <= '0;
            paddr  <= '0;
            pdata  <= '0;
            parked <= 1'b0;
            ebase  <= '0;
            eblk   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            unique case (mode)
                MD_READY: begin
                    if (cmd.kind == CK_PROG && tgt_blank) begin
                        mode   <= MD_PROG;
                        pcnt   <= CNT_W'(PROG_CYC);
                        paddr  <= cmd.addr[AW-1:0];
                        pdata  <= cmd.data;
                        parked <= 1'b0;
                    end else if ((cmd.kind == CK_SECT || cmd.kind == CK_BLK) && !prot_hit) begin
                        mode  <= MD_ERASE;
                        ecnt  <= CNT_W'(ERASE_CYC);
                        ebase <= cmd.addr;
                        eblk  <= (cmd.kind == CK_BLK);
                    end
                end
                MD_PROG: begin
                    if (pcnt <= 1) begin
                        mem[paddr] <= pdata;
                        mode       <= parked ? MD_SUSP : MD_READY;
                    end else begin
                        pcnt <= pcnt - 1'b1;
                    end
                end
                MD_ERASE: begin
                    if (cmd.kind == CK_SUSP) begin
                        mode <= MD_SUSPING;
                        pcnt <= CNT_W'(SUSP_CYC);
                    end else if (ecnt <= 1) begin
                        for (int i = 0; i < DEPTH; i++)
                            if (same_unit(BUS_AW'(i), ebase, AW, eshift)) mem[i] <= '1;
                        mode <= MD_READY;
                    end else begin
                        ecnt <= ecnt - 1'b1;
                    end
                end
                MD_SUSPING: begin
                    if (pcnt <= 1) mode <= MD_SUSP;
                    else           pcnt <= pcnt - 1'b1;
                end
                MD_SUSP: begin
                    if (cmd.kind == CK_PROG && tgt_blank && !in_susp) begin
                        mode   <= MD_PROG;
                        pcnt   <= CNT_W'(PROG_CYC);
                        paddr  <= cmd.addr[AW-1:0];
                        pdata  <= cmd.data;
                        parked <= 1'b1;
                    end else if (cmd.kind == CK_RESUME) begin
                        mode <= MD_ERASE;
                    end
                end
                default: mode <= MD_READY;
            endcase
        end
    end
endmodule

// File: rtl/fcsm_rdout.sv
module fcsm_rdout
    import fcsm_pkg::*;
#(
    parameter int AW      = 8,
    parameter int SECT_AW = 4,
    parameter int BLK_AW  = 6
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [BUS_AW-1:0] addr,
    input  mode_e             mode,
    input  logic [WORD_W-1:0] rword,
    input  logic [WORD_W-1:0] pdata,
    input  logic [BUS_AW-1:0] ebase,
    input  logic              eblk,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe
);
    logic rd_act, rd_q, rd_end, busy, in_unit, t6, t2;

    assign rd_act  = !ce_n && !oe_n;
    assign rd_end  = rd_q && !rd_act;
    assign busy    = is_busy(mode);
    assign in_unit = (mode == MD_SUSP) && same_unit(addr, ebase, AW, eblk ? BLK_AW : SECT_AW);
    assign dq_oe   = rd_act;

    always_comb begin
        dq_out = '0;
        if (rd_act) begin
            if (busy) begin
                dq_out[7] = (mode == MD_PROG) ? ~pdata[7] : 1'b0;
                dq_out[6] = t6;
            end else if (in_unit) begin
                dq_out[6] = 1'b1;
                dq_out[2] = t2;
            end else begin
                dq_out = rword;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            t6   <= 1'b0;
            t2   <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (rd_end) begin
                if (busy)         t6 <= ~t6;
                else if (in_unit) t2 <= ~t2;
            end
        end
    end
endmodule

// File: rtl/fcsm_top.sv
module fcsm_top
    import fcsm_pkg::*;
#(
    parameter int AW        = 8,
    parameter int SECT_AW   = 4,
    parameter int BLK_AW    = 6,
    parameter int PROT_BLK  = 0,
    parameter int PROG_CYC  = 40,
    parameter int ERASE_CYC = 80,
    parameter int SUSP_CYC  = 10
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic        wp_n,
    input  logic [15:0] addr,
    input  logic [15:0] dq_in,
    output logic [15:0] dq_out,
    output logic        dq_oe
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ?
                             ((ERASE_CYC > SUSP_CYC) ? ERASE_CYC : SUSP_CYC) :
                             ((PROG_CYC > SUSP_CYC) ? PROG_CYC : SUSP_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    logic              wr_evt;
    wr_t               wr;
    cmd_t              cmd;
    mode_e             mode_w;
    logic [WORD_W-1:0] rword, pdata;
    logic [BUS_AW-1:0] ebase;
    logic              eblk;
    logic [CNT_W-1:0]  ecnt_w;

    fcsm_wr_capture u_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .din(dq_in), .wr_evt(wr_evt), .wr(wr)
    );

    fcsm_cmd_decode u_dec (
        .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr(wr),
        .busy(is_busy(mode_w)), .cmd(cmd)
    );

    fcsm_core #(
        .AW(AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW), .PROT_BLK(PROT_BLK),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SUSP_CYC(SUSP_CYC), .CNT_W(CNT_W)
    ) u_core (
        .clk(clk), .rst(rst), .wp_n(wp_n), .cmd(cmd), .raddr(addr[AW-1:0]),
        .mode(mode_w), .rword(rword), .pdata(pdata), .ebase(ebase), .eblk(eblk),
        .ecnt(ecnt_w)
    );

    fcsm_rdout #(.AW(AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW)) u_rd (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
        .mode(mode_w), .rword(rword), .pdata(pdata), .ebase(ebase), .eblk(eblk),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/fcsm_chk.sv
module fcsm_chk
    import fcsm_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input logic             clk,
    input logic             rst,
    input logic             dq_oe,
    input logic [15:0]      dq_out,
    input mode_e            mode,
    input logic [CNT_W-1:0] ecnt
);
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> dq_out == 16'h0000); // R12

    AST_PROG_EXIT: assert property (@(posedge clk) disable iff (rst)
        mode == MD_PROG |=> mode inside {MD_PROG, MD_READY, MD_SUSP}); // R2

    AST_ERASE_EXIT: assert property (@(posedge clk) disable iff (rst)
        mode == MD_ERASE |=> mode inside {MD_ERASE, MD_READY, MD_SUSPING}); // R6

    AST_SUSPEND_ENTRY: assert property (@(posedge clk) disable iff (rst)
        mode == MD_SUSPING |=> mode inside {MD_SUSPING, MD_SUSP}); // R7

    AST_SUSPEND_EXIT: assert property (@(posedge clk) disable iff (rst)
        mode == MD_SUSP |=> mode inside {MD_SUSP, MD_ERASE, MD_PROG}); // R9

    AST_ERASE_TIME_KEPT: assert property (@(posedge clk) disable iff (rst)
        mode inside {MD_SUSP, MD_SUSPING} |=> $stable(ecnt)); // R7
endmodule

bind fcsm_top fcsm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .dq_oe(dq_oe), .dq_out(dq_out),
    .mode(mode_w), .ecnt(ecnt_w)
);

// File: tb/sim_fcsm_top.sv
module sim_fcsm_top;
    localparam int PROG_CYC  = 40;
    localparam int ERASE_CYC = 80;
    localparam int SUSP_CYC  = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp_n = 1'b1;
    logic [15:0] addr = '0, dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [256];

    always #4 clk = ~clk;

    fcsm_top u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wp_n(wp_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
        idle(2);
        we_n = 1'b1; ce_n = 1'b1;
        idle(2);
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v, output logic oe);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        idle(2);
        v = dq_out; oe = dq_oe;
        oe_n = 1'b1; ce_n = 1'b1;
        idle(1);
    endtask

    task automatic prog(input logic [15:0] a, input logic [15:0] d);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0); wr(a, d);
    endtask

    task automatic erase(input logic [15:0] a, input logic blk);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(a, blk ? 16'h0050 : 16'h0030);
    endtask

    function automatic void model_clear(input int base, input int size);
        for (int i = base; i < base + size; i++) model[i] = 16'hFFFF;
    endfunction

    task automatic scan(input string rq);
        logic [15:0] v; logic oe;
        for (int i = 0; i < 256; i++) begin
            rd(16'(i), v, oe);
            chk(rq, v, model[i]);
        end
    endtask

    initial begin
        idle(200000);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, v2, a, d;
        logic oe;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        idle(3);
        rst = 1'b0;
        idle(2);

        // R13: reset state
        scan("R13");

        // R12: bus quiet unless both enables low
        addr = 16'h0001; ce_n = 1'b0; oe_n = 1'b1; idle(2);
        chk("R12", {15'd0, dq_oe}, 16'h0000); chk("R12", dq_out, 16'h0000);
        ce_n = 1'b1; oe_n = 1'b0; idle(2);
        chk("R12", {15'd0, dq_oe}, 16'h0000); chk("R12", dq_out, 16'h0000);
        oe_n = 1'b1; idle(1);
        rd(16'h0001, v, oe);
        chk("R12", {15'd0, oe}, 16'h0001);

        // R1: address from first low cycle, data from last low cycle
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
        addr = 16'h0003; dq_in = 16'h1234; ce_n = 1'b0; we_n = 1'b0;
        idle(1);
        addr = 16'h0077; dq_in = 16'h5A5A;
        idle(2);
        we_n = 1'b1; ce_n = 1'b1;
        idle(PROG_CYC + 8);
        model[8'h03] = 16'h5A5A;
        rd(16'h0003, v, oe); chk("R1", v, 16'h5A5A);
        rd(16'h0077, v, oe); chk("R1", v, 16'hFFFF);

        // R2/R3: random programs with model-predicted acceptance
        for (int n = 0; n < 24; n++) begin
            a = 16'h0080 + 16'($urandom % 96);
            d = 16'($urandom);
            if (n % 6 == 5) a = 16'h0080;      // repeat hit on a written word
            prog(a, d);
            idle(PROG_CYC + 6);
            if (model[a[7:0]] == 16'hFFFF) begin
                model[a[7:0]] = d;
                rd(a, v, oe); chk("R2", v, d);
            end else begin
                rd(a, v, oe); chk("R3", v, model[a[7:0]]);
            end
        end
        // R3: no busy status on a rejected program
        prog(16'h0003, 16'h0000);
        rd(16'h0003, v, oe); chk("R3", v, 16'h5A5A);

        // R11: broken sequence returns to idle
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0012);
        wr(16'h5555, 16'h00A0); wr(16'h00F8, 16'h0F0F);
        idle(PROG_CYC + 6);
        rd(16'h00F8, v, oe); chk("R11", v, 16'hFFFF);

        // R6: program status, toggle, and ignored commands while busy
        prog(16'h00F0, 16'h0003);
        rd(16'h00F0, v, oe); chk("R6", v & 16'hFFBF, 16'h0080);
        rd(16'h00F0, v2, oe); chk("R6", v2 & 16'hFFBF, 16'h0080);
        chk("R6", 16'((v ^ v2) & 16'h0040), 16'h0040);
        prog(16'h00F1, 16'h1111);
        idle(PROG_CYC + 6);
        model[8'hF0] = 16'h0003;
        rd(16'h00F0, v, oe); chk("R2", v, 16'h0003);
        rd(16'h00F1, v, oe); chk("R6", v, 16'hFFFF);

        // R4: sector erase, erase status during busy
        prog(16'h0024, 16'h2424); idle(PROG_CYC + 6); model[8'h24] = 16'h2424;
        prog(16'h0031, 16'h3131); idle(PROG_CYC + 6); model[8'h31] = 16'h3131;
        erase(16'h0020, 1'b0);
        rd(16'h0024, v, oe); chk("R6", v & 16'hFFBF, 16'h0000);
        rd(16'h0024, v2, oe); chk("R6", 16'((v ^ v2) & 16'h0040), 16'h0040);
        idle(ERASE_CYC + 6);
        model_clear(32, 16);
        scan("R4");

        // R10: protected block 0 with wp_n low, then allowed with wp_n high
        wp_n = 1'b0;
        erase(16'h0005, 1'b1);
        rd(16'h0003, v, oe); chk("R10", v, 16'h5A5A);
        idle(ERASE_CYC + 6);
        rd(16'h0031, v, oe); chk("R10", v, 16'h3131);
        wp_n = 1'b1;
        erase(16'h0005, 1'b1);
        idle(ERASE_CYC + 6);
        model_clear(0, 64);
        // R5: whole 64-word block cleared, others kept
        scan("R5");

        // R7/R8/R9: suspend, program around it, resume
        prog(16'h0012, 16'h1212); idle(PROG_CYC + 6); model[8'h12] = 16'h1212;
        prog(16'h0045, 16'h4545); idle(PROG_CYC + 6); model[8'h45] = 16'h4545;
        erase(16'h0010, 1'b0);
        idle(4);
        wr(16'h0000, 16'h00B0);
        idle(SUSP_CYC + 6);
        rd(16'h0012, v, oe); chk("R7", v & 16'hFFFB, 16'h0040);
        rd(16'h0012, v2, oe); chk("R7", v2 & 16'hFFFB, 16'h0040);
        chk("R7", 16'((v ^ v2) & 16'h0004), 16'h0004);
        rd(16'h0045, v, oe); chk("R7", v, 16'h4545);
        prog(16'h0013, 16'h2222);
        idle(PROG_CYC + 6);
        rd(16'h0013, v, oe); chk("R8", v & 16'hFFFB, 16'h0040);
        prog(16'h0046, 16'h6666);
        idle(PROG_CYC + 6);
        model[8'h46] = 16'h6666;
        rd(16'h0046, v, oe); chk("R8", v, 16'h6666);
        rd(16'h0012, v, oe); chk("R8", v & 16'hFFFB, 16'h0040);
        wr(16'h0000, 16'h0030);
        rd(16'h0012, v, oe); chk("R9", v & 16'hFFBF, 16'h0000);
        idle(ERASE_CYC + 6);
        model_clear(16, 16);
        scan("R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule